// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Overflow Trap

This unit performs 32-bit addition or subtraction on operands whose two least significant bits carry a type tag. A properly formed tagged integer has both tag bits clear. A nonzero tag bit on either operand is a tag mismatch. Each operation presented with the valid strobe produces a registered result and a registered set of condition flags: negative, zero, overflow and carry.

The unit has two modes. In flag mode, the overflow flag reports either signed arithmetic overflow or a tag mismatch. In trap mode, a tag mismatch or a signed overflow does not write the result or the flags. Instead the unit raises a one-cycle tag-overflow trap pulse. A trap-mode operation that does not trap writes negative, zero and carry, and clears the overflow flag. What happens after a trap is handled outside this unit.

Every output is registered. Results, flags, the write enable and the trap pulse all appear on the clock edge that follows the edge sampling the valid strobe.

Top module: `tagged_arith_unit`

## Requirements
- R1: An add (op_sub=0) accepted with in_valid drives res_out = (opnd_a + opnd_b) mod 2^32, with res_we high for exactly the following cycle.
- R2: A subtract (op_sub=1) drives res_out = (opnd_a - opnd_b) mod 2^32, with flag_c set exactly when opnd_a < opnd_b as unsigned values (borrow).
- R3: For an add, flag_c is the unsigned carry out of bit 31.
- R4: On every write, flag_n equals bit 31 of the result and flag_z is set exactly when the result is zero.
- R5: In flag mode (trap_mode=0), flag_v is set when signed overflow occurs or when bit 1 or bit 0 of either operand is nonzero.
- R6: In trap mode (trap_mode=1), if bits 1:0 of either operand are nonzero or signed overflow occurs, tag_trap is high for the following cycle only, res_we stays low, and res_out and all flags keep their previous values.
- R7: In trap mode with no trap, res_out, flag_n, flag_z and flag_c are written as in R1 to R4, and flag_v is cleared.
- R8: While in_valid is low, res_we and tag_trap stay low, and res_out and the flags keep their values.
- R9: A synchronous active-high reset clears res_out, all flags, res_we and tag_trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| trap_mode | input | 1 | 0 = report in flags, 1 = trap on tag or overflow |
| opnd_a | input | 32 | First operand (minuend for subtract) |
| opnd_b | input | 32 | Second operand (subtrahend for subtract) |
| res_out | output | 32 | Registered result |
| res_we | output | 1 | Result and flags were written this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry (add) or borrow (subtract) flag |
| tag_trap | output | 1 | One-cycle tag-overflow trap pulse |

## Verification
On every cycle the assertions check several things. A trap and a write never occur together. Either pulse occurs only after an accepted operation. Idle cycles leave the flags untouched. Zero tracks the result. Overflow is forced in flag mode when a tag bit was set, and it is clear after a trap-mode write. The exact arithmetic can be shown only by the bench's cycle-by-cycle reference comparison. This covers carry against borrow, the signed overflow boundaries, the choice between trapping on overflow and trapping on tag, and the values held through a trap. The bench runs directed corner cases and then a long mixed run of aligned and misaligned operands.

// File: rtl/tagarith_pkg.sv
package tagarith_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/tag_detect.sv
module tag_detect #(
  parameter int TAG_W = 2
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             mismatch
);
  generate
    if (TAG_W > 0) begin : g_tag
      assign mismatch = |(tag_a | tag_b);
    end else begin : g_notag
      assign mismatch = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/addsub_core.sv
module addsub_core
  import tagarith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output cc_t               cc
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum   = wide[MSB:0];
    cc.n  = sum[MSB];
    cc.z  = (sum == '0);
    // signed overflow: operands agree in sign, result differs
    cc.v  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    // carry for add, borrow (inverted carry) for subtract
    cc.c  = sub ? ~wide[DATA_W] : wide[DATA_W];
  end
endmodule

// File: rtl/outcome_reg.sv
module outcome_reg
  import tagarith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              fire,
  input  logic [DATA_W-1:0] nxt_res,
  input  cc_t               nxt_cc,
  output logic [DATA_W-1:0] res_q,
  output cc_t               cc_q,
  output logic              we_q,
  output logic              trap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cc_q   <= '0;
      we_q   <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      we_q   <= commit;
      trap_q <= fire;
      if (commit) begin
        res_q <= nxt_res;
        cc_q  <= nxt_cc;
      end
    end
  end
endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
  import tagarith_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic              trap_mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_out,
  output logic              res_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              tag_trap
);
  logic              tag_bad;
  logic [DATA_W-1:0] core_sum;
  cc_t               core_cc;
  cc_t               wr_cc;
  cc_t               cc_q;
  logic              fire;
  logic              commit;

  tag_detect #(.TAG_W(TAG_W)) u_tag (
    .tag_a   (opnd_a[TAG_W-1:0]),
    .tag_b   (opnd_b[TAG_W-1:0]),
    .mismatch(tag_bad)
  );

  addsub_core #(.DATA_W(DATA_W)) u_core (
    .a  (opnd_a),
    .b  (opnd_b),
    .sub(op_sub),
    .sum(core_sum),
    .cc (core_cc)
  );

  always_comb begin
    fire   = in_valid & trap_mode & (tag_bad | core_cc.v);
    commit = in_valid & ~fire;
    wr_cc  = core_cc;
    wr_cc.v = trap_mode ? 1'b0 : (core_cc.v | tag_bad);
  end

  outcome_reg #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .fire   (fire),
    .nxt_res(core_sum),
    .nxt_cc (wr_cc),
    .res_q  (res_out),
    .cc_q   (cc_q),
    .we_q   (res_we),
    .trap_q (tag_trap)
  );

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;
endmodule

// File: rtl/tagged_arith_chk.sv
module tagged_arith_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              trap_mode,
  input logic [TAG_W-1:0]  tag_or,
  input logic [DATA_W-1:0] res_out,
  input logic              res_we,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c,
  input logic              tag_trap
);
  // R6: trap and write are mutually exclusive
  p_trap_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(tag_trap && res_we));

  // R6: a trap follows only a trap-mode operation
  p_trap_src_r6: assert property (@(posedge clk) disable iff (rst)
    tag_trap |-> ($past(in_valid) && $past(trap_mode)));

  // R1: write follows only an accepted operation
  p_we_src_r1: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(in_valid));

  // R8: idle cycle holds the flags and raises nothing
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      (!res_we && !tag_trap && $stable({flag_n, flag_z, flag_v, flag_c})));

  // R4: zero flag tracks the written result
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (flag_z == (res_out == '0)));

  // R5: flag mode with a tag bit set reports overflow
  p_tag_v_r5: assert property (@(posedge clk) disable iff (rst)
    (res_we && !$past(trap_mode) && ($past(tag_or) != '0)) |-> flag_v);

  // R7: trap-mode write clears overflow
  p_vclr_r7: assert property (@(posedge clk) disable iff (rst)
    (res_we && $past(trap_mode)) |-> !flag_v);
endmodule

bind tagged_arith_unit tagged_arith_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .trap_mode(trap_mode),
  .tag_or   (opnd_a[TAG_W-1:0] | opnd_b[TAG_W-1:0]),
  .res_out  (res_out),
  .res_we   (res_we),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .tag_trap (tag_trap)
);

// File: tb/test_tagged_arith_unit.sv
module test_tagged_arith_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic        trap_mode = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] res_out;
  logic        res_we, flag_n, flag_z, flag_v, flag_c, tag_trap;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_res = '0;
  logic        m_we = 0, m_n = 0, m_z = 0, m_v = 0, m_c = 0, m_trap = 0;

  always #5 clk = ~clk;

  tagged_arith_unit i_tagged_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .trap_mode(trap_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_out(res_out), .res_we(res_we), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .tag_trap(tag_trap)
  );

  task automatic model_step(input bit v, input bit s, input bit tm,
                            input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, sr;
    logic [31:0] r;
    bit ovf, tagbad, carry;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sr = s ? (sa - sb) : (sa + sb);
    ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    r = s ? (a - b) : (a + b);
    carry = s ? (a < b) : ((longint'(a) + longint'(b)) > 64'd4294967295);
    tagbad = (a % 4 != 0) || (b % 4 != 0);
    m_we = 0;
    m_trap = 0;
    if (v) begin
      if (tm && (tagbad || ovf)) begin
        m_trap = 1;
      end else begin
        m_we = 1;
        m_res = r;
        m_n = r[31];
        m_z = (r == 0);
        m_c = carry;
        m_v = tm ? 1'b0 : (ovf || tagbad);
      end
    end
  endtask

  task automatic compare(input string req);
    vectors++;
    if (res_out !== m_res || res_we !== m_we || tag_trap !== m_trap ||
        {flag_n, flag_z, flag_v, flag_c} !== {m_n, m_z, m_v, m_c}) begin
      miscompares++;
      $display("FAIL %s: got res=%h we=%b nzvc=%b%b%b%b trap=%b exp res=%h we=%b nzvc=%b%b%b%b trap=%b",
               req, res_out, res_we, flag_n, flag_z, flag_v, flag_c, tag_trap,
               m_res, m_we, m_n, m_z, m_v, m_c, m_trap);
    end
  endtask

  task automatic op(input bit v, input bit s, input bit tm,
                    input logic [31:0] a, input logic [31:0] b, input string req);
    @(negedge clk);
    in_valid = v; op_sub = s; trap_mode = tm; opnd_a = a; opnd_b = b;
    model_step(v, s, tm, a, b);
    @(posedge clk);
    #1;
    compare(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(posedge clk);
    #1;
    m_res = '0; m_we = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_trap = 0;
    compare("R9");
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R9");
    @(negedge clk);
    rst = 0;

    op(1, 0, 0, 32'd8, 32'd4, "R1");
    op(1, 0, 0, 32'hFFFF_FFFC, 32'd8, "R3");
    op(1, 0, 0, 32'hFFFF_FFFC, 32'd4, "R4");
    op(1, 0, 0, 32'h8000_0000, 32'h0000_0010, "R4");
    op(1, 0, 0, 32'h7FFF_FFFC, 32'd4, "R5");
    op(1, 0, 0, 32'd5, 32'd8, "R5");
    op(1, 0, 0, 32'd8, 32'd2, "R5");
    op(1, 1, 0, 32'd8, 32'd4, "R2");
    op(1, 1, 0, 32'd4, 32'd8, "R2");
    op(1, 1, 0, 32'd4, 32'd4, "R4");
    op(1, 1, 0, 32'h8000_0000, 32'd4, "R5");
    op(0, 0, 0, 32'h1234_5677, 32'h0000_0003, "R8");
    op(0, 1, 1, 32'h0000_0001, 32'hFFFF_FFFF, "R8");
    op(1, 0, 1, 32'd9, 32'd4, "R6");
    op(1, 1, 1, 32'd8, 32'd3, "R6");
    op(1, 0, 1, 32'h7FFF_FFFC, 32'd4, "R6");
    op(1, 1, 1, 32'h8000_0000, 32'd4, "R6");
    op(1, 0, 1, 32'hFFFF_FFFC, 32'd8, "R7");
    op(1, 1, 1, 32'd4, 32'd8, "R7");
    op(1, 0, 0, 32'd1, 32'd0, "R5");
    op(1, 0, 1, 32'd4, 32'd4, "R7");
    op(0, 0, 0, 32'd0, 32'd0, "R8");

    do_reset();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      bit v, s, tm;
      a = $urandom;
      b = $urandom;
      if (($urandom % 3) != 0) begin
        a[1:0] = 2'b00;
        b[1:0] = 2'b00;
      end
      v = ($urandom % 4) != 0;
      s = $urandom % 2;
      tm = $urandom % 2;
      op(v, s, tm, a, b, !v ? "R8" : tm ? "R6" : s ? "R2" : "R1");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule